// File: doc/BRIEF.md
# Synchronizable Switching Clock Generator

This block produces the cycle-start strobe that opens every switching period of a buck-type regulator controller. Left alone, it counts a fixed number of reference-clock ticks per period and issues a one-tick strobe at each boundary. When an external synchronization waveform is present, each falling edge of that waveform starts a new period instead. The input passes through a two-flop synchronizer and is edge-detected inside the block.

Edges that come too soon after the previous start are discarded, which caps the accepted external rate. If no usable edge arrives for one and a half nominal periods, the block issues a start on its own and drops back to free-running. A sync line held low therefore gives the free-running rate.

A short-circuit flag, taken from a feedback-voltage comparator, stretches the free-running period to three times its nominal length. The flag is sampled only at period boundaries. Each strobe also opens a minimum on-time window of fixed length. Downstream turn-off logic must disregard its requests while that window is high.

Top module: `swclk_gen`

## Requirements
- R1: During reset both outputs are 0. After reset, with `sync_in` high and `short_flag` low, `cycle_start` is a single-tick pulse. The first pulse comes PERIOD ticks after reset is released, and later pulses follow at intervals of exactly PERIOD ticks.
- R2: A high-to-low transition of `sync_in` that is accepted makes `cycle_start` rise in the third clock cycle after the first rising edge that samples the low level. An edge is accepted when it is detected at least SYNC_GAP ticks after the previous start. While accepted edges keep arriving within the timeout, no free-running pulse appears between them.
- R3: A falling edge detected fewer than SYNC_GAP ticks after the previous cycle start is ignored. It produces no pulse and does not restart the period.
- R4: After an accepted sync edge, if no further accepted edge comes within TIMEOUT = PERIOD*3/2 (integer division) ticks of the last start, a start is issued exactly TIMEOUT ticks after it. The block then returns to free-running.
- R5: With `sync_in` held continuously low, the block free-runs at PERIOD ticks. A rising edge of `sync_in` has no effect on the timing.
- R6: `short_flag` is sampled in the tick just before each `cycle_start` pulse. The period that follows lasts 3*PERIOD ticks if the flag was 1 and PERIOD ticks if it was 0. The period already in progress is never cut short or lengthened.
- R7: `min_on` is 1 for exactly MIN_ON consecutive ticks, beginning in the tick where `cycle_start` is 1.
- R8: An accepted sync edge starts a cycle even during a period stretched by `short_flag`, with the same latency as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick is one count unit |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_in | input | 1 | External synchronization waveform (asynchronous; falling edge starts a period) |
| short_flag | input | 1 | Feedback-below-threshold flag; when high, the free-running period is tripled |
| cycle_start | output | 1 | One-tick strobe at the start of each switching period |
| min_on | output | 1 | High during the minimum on-time window of each period |

## Verification
Free-running strobes are due PERIOD ticks apart, or 3*PERIOD ticks when folded. A sync-driven strobe is due three rising edges after the low level is first sampled. A timeout strobe is due TIMEOUT ticks after the last start. The window stays high for MIN_ON ticks starting at the strobe. The bench drives inputs on falling clock edges and samples outputs on falling edges. It counts falling edges from a known reference point, either a drive or the previous strobe, up to the next strobe, and compares that count with the figure derived from the requirement. In the stretches where no strobe may appear, it also counts strobes and expects none.

// File: rtl/swclk_pkg.sv
package swclk_pkg;
   typedef enum logic {
      TIMING_FREE = 1'b0,
      TIMING_EXT  = 1'b1
   } timing_src_e;
endpackage

// File: rtl/swclk_edge_sync.sv
module swclk_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_o
);
   localparam int TAPS = STAGES + 1;

   logic [TAPS-1:0] tap_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("swclk_edge_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < TAPS; g++) begin : g_tap
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) tap_q[0] <= 1'b1;
               else        tap_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) tap_q[g] <= 1'b1;
               else        tap_q[g] <= tap_q[g-1];
            end
         end
      end
   endgenerate

   assign fall_o = tap_q[TAPS-1] & ~tap_q[TAPS-2];

   // R2: a detected falling edge lasts a single tick
   p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/swclk_sched.sv
module swclk_sched
   import swclk_pkg::*;
#(
   parameter int PERIOD   = 25,
   parameter int SYNC_GAP = 12,
   parameter int FOLD_DIV = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fall_i,
   input  logic short_i,
   output logic start_o
);
   localparam int TIMEOUT  = (PERIOD * 3) / 2;
   localparam int LONGEST  = (PERIOD * FOLD_DIV > TIMEOUT) ? PERIOD * FOLD_DIV : TIMEOUT;
   localparam int CW       = $clog2(LONGEST + 1);
   localparam logic [CW-1:0] LAST_NORM = CW'(PERIOD - 1);
   localparam logic [CW-1:0] LAST_FOLD = CW'(PERIOD * FOLD_DIV - 1);
   localparam logic [CW-1:0] LAST_TMO  = CW'(TIMEOUT - 1);
   localparam logic [CW-1:0] GAP_MIN   = CW'(SYNC_GAP - 1);

   logic [CW-1:0] cnt_q;
   timing_src_e   src_q;
   logic          fold_q;
   logic          start_q;
   logic [CW-1:0] last_free;
   logic          gap_ok, edge_go, free_go, tmo_go, start_now;

   assign last_free = fold_q ? LAST_FOLD : LAST_NORM;
   assign gap_ok    = (cnt_q >= GAP_MIN);
   assign edge_go   = fall_i & gap_ok;
   assign free_go   = (src_q == TIMING_FREE) && (cnt_q == last_free);
   assign tmo_go    = (src_q == TIMING_EXT) && (cnt_q == LAST_TMO);
   assign start_now = edge_go | free_go | tmo_go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         src_q   <= TIMING_FREE;
         fold_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         start_q <= start_now;
         if (start_now) begin
            cnt_q  <= '0;
            fold_q <= short_i;
            if (edge_go)     src_q <= TIMING_EXT;
            else if (tmo_go) src_q <= TIMING_FREE;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign start_o = start_q;

   // R3: no start is issued closer than SYNC_GAP ticks to the previous one
   p_min_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> ($past(cnt_q) >= GAP_MIN));
   // R4: in external timing the count never passes the timeout
   p_tmo_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == TIMING_EXT) |-> (cnt_q <= LAST_TMO));
   // R6: the fold setting changes only at a cycle boundary
   p_fold_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !start_now |=> $stable(fold_q));
   // R1: free-running count stays inside the selected period
   p_free_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q == TIMING_FREE) |-> (cnt_q <= last_free));
endmodule

// File: rtl/swclk_on_window.sv
module swclk_on_window #(
   parameter int MIN_ON = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic win_o
);
   localparam int OW = $clog2(MIN_ON + 1);
   localparam logic [OW-1:0] LOAD = OW'(MIN_ON - 1);

   logic [OW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              left_q <= '0;
      else if (start_i)        left_q <= LOAD;
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign win_o = start_i | (left_q != '0);

   // R7: the window is open whenever a period starts
   p_win_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> win_o);
   // R7: remaining count never exceeds the window length
   p_win_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= LOAD);
endmodule

// File: rtl/swclk_gen.sv
module swclk_gen #(
   parameter int PERIOD      = 25,
   parameter int MIN_ON      = 7,
   parameter int SYNC_GAP    = 12,
   parameter int FOLD_DIV    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic short_flag,
   output logic cycle_start,
   output logic min_on
);
   generate
      if (MIN_ON < 1 || MIN_ON > SYNC_GAP) begin : g_bad_min_on
         $error("swclk_gen: MIN_ON must lie in 1..SYNC_GAP");
      end
      if (SYNC_GAP < 2 || SYNC_GAP > PERIOD) begin : g_bad_gap
         $error("swclk_gen: SYNC_GAP must lie in 2..PERIOD");
      end
      if (FOLD_DIV < 1) begin : g_bad_fold
         $error("swclk_gen: FOLD_DIV must be positive");
      end
   endgenerate

   logic fall_w;
   logic start_w;

   swclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sync_in),
      .fall_o   (fall_w)
   );

   swclk_sched #(
      .PERIOD   (PERIOD),
      .SYNC_GAP (SYNC_GAP),
      .FOLD_DIV (FOLD_DIV)
   ) u_sched (
      .clk     (clk),
      .rst_n   (rst_n),
      .fall_i  (fall_w),
      .short_i (short_flag),
      .start_o (start_w)
   );

   swclk_on_window #(.MIN_ON(MIN_ON)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_w),
      .win_o   (min_on)
   );

   assign cycle_start = start_w;

   // R1: the strobe is a single-tick pulse
   p_strobe_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_start |=> !cycle_start);
endmodule

// File: tb/sim_swclk_gen.sv
module sim_swclk_gen;
   localparam int PERIOD   = 25;
   localparam int MIN_ON   = 7;
   localparam int SYNC_GAP = 12;
   localparam int TIMEOUT  = (PERIOD * 3) / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_in = 1'b1;
   logic short_flag = 1'b0;
   logic cycle_start, min_on;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   swclk_gen #(.PERIOD(PERIOD), .MIN_ON(MIN_ON), .SYNC_GAP(SYNC_GAP)) u0 (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .short_flag(short_flag),
      .cycle_start(cycle_start), .min_on(min_on)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic to_strobe(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cycle_start && n < 500);
   endtask

   task automatic quiet_wait(input int ticks, output int seen);
      seen = 0;
      for (int i = 0; i < ticks; i++) begin
         @(negedge clk);
         if (cycle_start) seen++;
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk(cycle_start == 1'b0, "R1 reset strobe", cycle_start, 0);
      chk(min_on == 1'b0, "R1 reset window", min_on, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_free_run;
      int n;
      to_strobe(n);
      chk(n == PERIOD, "R1 first strobe", n, PERIOD);
      for (int i = 0; i < 3; i++) begin
         to_strobe(n);
         chk(n == PERIOD, "R1 free period", n, PERIOD);
      end
   endtask

   task automatic t_window;
      int n, w;
      to_strobe(n);
      chk(min_on == 1'b1, "R7 window at strobe", min_on, 1);
      w = 0;
      while (min_on && w < 100) begin
         w++;
         @(negedge clk);
      end
      chk(w == MIN_ON, "R7 window length", w, MIN_ON);
   endtask

   task automatic t_sync_train;
      int n, seen;
      to_strobe(n);
      repeat (15) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         if (i > 0) begin
            quiet_wait(27, seen);
            chk(seen == 0, "R2 no free strobe between edges", seen, 0);
         end
         sync_in = 1'b0;
         repeat (2) @(negedge clk);
         sync_in = 1'b1;
         to_strobe(n);
         chk(n == 1, "R2 sync latency", n + 2, 3);
      end
   endtask

   task automatic t_early_edge_and_timeout;
      int n;
      sync_in = 1'b0;
      to_strobe(n);
      chk(n != 3, "R3 early edge ignored", n, TIMEOUT);
      chk(n == TIMEOUT, "R4 timeout start", n, TIMEOUT);
   endtask

   task automatic t_held_low;
      int n;
      for (int i = 0; i < 2; i++) begin
         to_strobe(n);
         chk(n == PERIOD, "R5 held low free-runs", n, PERIOD);
      end
      sync_in = 1'b1;
      to_strobe(n);
      chk(n == PERIOD, "R5 rising edge no effect", n, PERIOD);
   endtask

   task automatic t_fold;
      int n;
      short_flag = 1'b1;
      to_strobe(n);
      chk(n == PERIOD, "R6 current period kept", n, PERIOD);
      to_strobe(n);
      chk(n == 3 * PERIOD, "R6 folded period", n, 3 * PERIOD);
      short_flag = 1'b0;
      to_strobe(n);
      chk(n == 3 * PERIOD, "R6 fold held to boundary", n, 3 * PERIOD);
      to_strobe(n);
      chk(n == PERIOD, "R6 fold released", n, PERIOD);
   endtask

   task automatic t_sync_in_fold;
      int n;
      short_flag = 1'b1;
      to_strobe(n);
      chk(n == PERIOD, "R8 boundary before fold", n, PERIOD);
      repeat (15) @(negedge clk);
      sync_in = 1'b0;
      repeat (2) @(negedge clk);
      sync_in = 1'b1;
      to_strobe(n);
      chk(n == 1, "R8 sync edge during fold", n + 2, 3);
      short_flag = 1'b0;
   endtask

   initial begin
      t_reset();
      t_free_run();
      t_window();
      t_sync_train();
      t_early_edge_and_timeout();
      t_held_low();
      t_fold();
      t_sync_in_fold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule